// File: doc/BRIEF.md
# Fan PWM Driver with Start-Up Boost

This block drives a single fan through a pulse-width modulated output. Software programs three small registers through a write-only port: the duty level, a configuration byte (start-up timeout, fixed-time start-up, output polarity, control mode) and an output-frequency code. Each PWM period is split into 255 equal steps. The output is active for as many leading steps as the duty value selects. All timing is derived from two clock-enable dividers set by parameters, so the same RTL serves full-scale and scaled-down timing.

A fan that stands still may not start at a low duty. When the duty register moves from zero to a nonzero value, the block therefore forces the output to its active level for a start-up phase. That phase ends at a timeout chosen by a 3-bit code. In the default mode it can end earlier, once two rising edges have arrived on the synchronized tachometer input. A configuration bit makes the phase always last the full timeout instead. When the phase is over, the output falls back to the programmed duty. New duty and frequency values take effect only at a period boundary, so no period is ever cut short.

Top module: `fan_pwm_drv`

## Requirements
- R1: After reset the duty register holds 0xFF, the frequency code is 100, the timeout code is 010, tachometer-ended start-up is selected, polarity is non-inverted and the mode is manual (111). The output is therefore at its active (high) level.
- R2: Writes decode by `wr_addr`. Address 0 is duty. Address 1 is configuration, with [2:0] the timeout code, [3] fixed-time start-up, [4] invert and [7:5] mode. Address 2 is the frequency code in [2:0]. A write to address 3 changes nothing.
- R3: A period has 255 steps, and the output is active during the first D steps, where D is the applied duty. D = 0x00 keeps the output inactive for the whole period and D = 0xFF keeps it active for the whole period, with no stray pulse.
- R4: One step lasts STEP_UNIT clock cycles multiplied by 16, 12, 8, 6, 5, 4, 3 or 2 for frequency codes 0 through 7. These multipliers are in the ratio of 11.0 to 88.2 Hz.
- R5: Written duty and frequency values are applied only in the cycle that follows the last step of the running period.
- R6: The output equals the active state XOR the invert bit. A change of the invert bit shows on the output in the cycle after the write.
- R7: A duty write is accepted only while the mode field is 111. In any other mode it leaves the duty register unchanged.
- R8: A duty write of a nonzero value while the duty register is zero and the timeout code is nonzero starts the start-up phase. From the next cycle the output is forced active until the phase ends.
- R9: The timeout codes 1 to 7 mean 100, 250, 400, 667, 1000, 2000 and 4000 millisecond ticks, each tick MS_DIV clocks long. The phase ends on the tick that completes the count.
- R10: With fixed-time start-up clear, the phase also ends after the second rising edge of the tachometer input, as seen after a two-flop synchronizer.
- R11: With fixed-time start-up set, tachometer edges do not shorten the phase.
- R12: With timeout code 000, no start-up phase is started. Writing duty 0 during the phase ends it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| pwm_out | output | 1 | Fan PWM drive |

## Verification
Two ways of ending the start-up phase can land in the same cycle: the second synchronized tachometer rise and the millisecond tick that completes the timeout. Either one must clear the phase exactly once, and the output must return to the applied duty in the next cycle. The bench sweeps the tachometer pulses across the timeout point, one cycle further each time, so that the two events meet in some runs. The reference model predicts the output on every clock, and any disagreement counts as a failure. A period boundary that meets a duty write, or the end of the phase, is exercised the same way.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int unsigned DUTY_W = 8;
  localparam int unsigned STEPS  = (1 << DUTY_W) - 1;
  localparam int unsigned MS_W   = 12;

  localparam logic [1:0] ADDR_DUTY = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_FREQ = 2'd2;

  localparam logic [2:0] MODE_MANUAL = 3'b111;

  typedef struct packed {
    logic [2:0] mode;
    logic       invert;
    logic       fixed_spin;
    logic [2:0] tsel;
  } fan_cfg_t;

  localparam fan_cfg_t CFG_RESET = '{mode: 3'b111, invert: 1'b0,
                                     fixed_spin: 1'b0, tsel: 3'b010};
  localparam logic [2:0]        FREQ_RESET = 3'b100;
  localparam logic [DUTY_W-1:0] DUTY_RESET = '1;

  // start-up length in millisecond ticks
  function automatic logic [MS_W-1:0] spin_ms(input logic [2:0] sel);
    case (sel)
      3'd1:    spin_ms = 12'd100;
      3'd2:    spin_ms = 12'd250;
      3'd3:    spin_ms = 12'd400;
      3'd4:    spin_ms = 12'd667;
      3'd5:    spin_ms = 12'd1000;
      3'd6:    spin_ms = 12'd2000;
      3'd7:    spin_ms = 12'd4000;
      default: spin_ms = 12'd0;
    endcase
  endfunction

  // step length in STEP_UNIT clocks per frequency code
  function automatic logic [4:0] step_mult(input logic [2:0] code);
    case (code)
      3'd0:    step_mult = 5'd16;
      3'd1:    step_mult = 5'd12;
      3'd2:    step_mult = 5'd8;
      3'd3:    step_mult = 5'd6;
      3'd4:    step_mult = 5'd5;
      3'd5:    step_mult = 5'd4;
      3'd6:    step_mult = 5'd3;
      default: step_mult = 5'd2;
    endcase
  endfunction
endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
  import fan_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DUTY_W-1:0] wr_data,
  output logic [DUTY_W-1:0] duty_q,
  output fan_cfg_t          cfg_q,
  output logic [2:0]        freq_q,
  output logic              spin_start,
  output logic              duty_clear
);
  logic [DUTY_W-1:0] duty_d;
  fan_cfg_t          cfg_d;
  logic [2:0]        freq_d;
  logic              duty_wr;

  assign duty_wr    = wr_en && (wr_addr == ADDR_DUTY) && (cfg_q.mode == MODE_MANUAL);
  assign spin_start = duty_wr && (duty_q == '0) && (wr_data != '0) && (cfg_q.tsel != 3'd0);
  assign duty_clear = duty_wr && (wr_data == '0);

  always_comb begin
    duty_d = duty_q;
    cfg_d  = cfg_q;
    freq_d = freq_q;
    if (duty_wr)                          duty_d = wr_data;
    if (wr_en && (wr_addr == ADDR_CFG))   cfg_d  = fan_cfg_t'(wr_data);
    if (wr_en && (wr_addr == ADDR_FREQ))  freq_d = wr_data[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= DUTY_RESET;
      cfg_q  <= CFG_RESET;
      freq_q <= FREQ_RESET;
    end else begin
      duty_q <= duty_d;
      cfg_q  <= cfg_d;
      freq_q <= freq_d;
    end
  end
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pwm_pkg::*;
#(
  parameter int unsigned STEP_UNIT = 2779
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_reg,
  input  logic [2:0]        freq_reg,
  output logic [DUTY_W-1:0] duty_act,
  output logic              active,
  output logic              period_end
);
  localparam int unsigned PRE_MAX   = STEP_UNIT * 16;
  localparam int unsigned PW        = $clog2(PRE_MAX + 1);
  localparam logic [DUTY_W-1:0] LAST_STEP = DUTY_W'(STEPS - 1);

  logic [PW-1:0]     pre_q, pre_d, pre_lim;
  logic [DUTY_W-1:0] cnt_q, cnt_d, dact_d;
  logic [2:0]        fact_q, fact_d;
  logic              step_en;

  assign pre_lim    = (PW'(STEP_UNIT) * PW'(step_mult(fact_q))) - PW'(1);
  assign step_en    = (pre_q == pre_lim);
  assign period_end = step_en && (cnt_q == LAST_STEP);
  assign active     = (cnt_q < duty_act);

  always_comb begin
    pre_d  = step_en ? '0 : pre_q + PW'(1);
    cnt_d  = cnt_q;
    dact_d = duty_act;
    fact_d = fact_q;
    if (step_en) cnt_d = period_end ? '0 : cnt_q + DUTY_W'(1);
    if (period_end) begin
      dact_d = duty_reg;
      fact_d = freq_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      cnt_q    <= '0;
      duty_act <= DUTY_RESET;
      fact_q   <= FREQ_RESET;
    end else begin
      pre_q    <= pre_d;
      cnt_q    <= cnt_d;
      duty_act <= dact_d;
      fact_q   <= fact_d;
    end
  end
endmodule

// File: rtl/fan_tach_sync.sv
module fan_tach_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_in,
  output logic tach_rise
);
  // SYNC_STAGES synchronizer flops plus one history flop
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q[0] <= 1'b0;
    else        sh_q[0] <= tach_in;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[i] <= 1'b0;
      else        sh_q[i] <= sh_q[i-1];
    end
  end

  assign tach_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/fan_spinup.sv
module fan_spinup
  import fan_pwm_pkg::*;
#(
  parameter int unsigned MS_DIV = 125000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spin_start,
  input  logic       duty_clear,
  input  logic       tach_rise,
  input  logic       fixed_spin,
  input  logic [2:0] tsel,
  output logic       spinning
);
  localparam int unsigned MW = $clog2(MS_DIV + 1);

  logic [MW-1:0]   ms_q, ms_d;
  logic            ms_tick;
  logic [MS_W-1:0] el_q, el_d, limit;
  logic [1:0]      tc_q, tc_d;
  logic            spin_d, done_time, done_tach;

  assign ms_tick   = (ms_q == MW'(MS_DIV - 1));
  assign limit     = spin_ms(tsel);
  assign done_time = ms_tick && (({1'b0, el_q} + (MS_W+1)'(1)) >= {1'b0, limit});
  assign done_tach = !fixed_spin && tach_rise && (tc_q == 2'd1);

  always_comb begin
    ms_d   = ms_tick ? '0 : ms_q + MW'(1);
    spin_d = spinning;
    el_d   = el_q;
    tc_d   = tc_q;
    if (spin_start) begin
      spin_d = 1'b1;
      el_d   = '0;
      tc_d   = '0;
    end else if (spinning) begin
      if (duty_clear || done_time || done_tach) spin_d = 1'b0;
      if (ms_tick) el_d = el_q + MS_W'(1);
      if (tach_rise && (tc_q != 2'd2)) tc_d = tc_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q     <= '0;
      spinning <= 1'b0;
      el_q     <= '0;
      tc_q     <= '0;
    end else begin
      ms_q     <= ms_d;
      spinning <= spin_d;
      el_q     <= el_d;
      tc_q     <= tc_d;
    end
  end
endmodule

// File: rtl/fan_pwm_drv.sv
module fan_pwm_drv
  import fan_pwm_pkg::*;
#(
  parameter int unsigned STEP_UNIT   = 2779,
  parameter int unsigned MS_DIV      = 125000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       tach_in,
  output logic       pwm_out
);
  logic [DUTY_W-1:0] duty_q, duty_act;
  fan_cfg_t          cfg_q;
  logic [2:0]        freq_q;
  logic              spin_start, duty_clear, tach_rise;
  logic              active, period_end, spinning;

  fan_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .duty_q(duty_q), .cfg_q(cfg_q), .freq_q(freq_q),
    .spin_start(spin_start), .duty_clear(duty_clear)
  );

  fan_pwm_gen #(.STEP_UNIT(STEP_UNIT)) u_gen (
    .clk(clk), .rst_n(rst_n), .duty_reg(duty_q), .freq_reg(freq_q),
    .duty_act(duty_act), .active(active), .period_end(period_end)
  );

  fan_tach_sync #(.SYNC_STAGES(SYNC_STAGES)) u_tach (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .tach_rise(tach_rise)
  );

  fan_spinup #(.MS_DIV(MS_DIV)) u_spin (
    .clk(clk), .rst_n(rst_n), .spin_start(spin_start), .duty_clear(duty_clear),
    .tach_rise(tach_rise), .fixed_spin(cfg_q.fixed_spin), .tsel(cfg_q.tsel),
    .spinning(spinning)
  );

  assign pwm_out = (spinning | active) ^ cfg_q.invert;
endmodule

// File: rtl/fan_pwm_drv_chk.sv
module fan_pwm_drv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       pwm_out,
  input logic [7:0] cfg_bits,
  input logic [7:0] duty_reg,
  input logic [7:0] duty_act,
  input logic       period_end,
  input logic       spin_start,
  input logic       spinning
);
  // R3
  zero_duty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spinning && duty_act == 8'h00) |-> (pwm_out == cfg_bits[4]));

  // R3
  full_duty_solid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == 8'hFF) |-> (pwm_out == !cfg_bits[4]));

  // R5
  duty_holds_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(duty_act));

  // R8
  spin_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spin_start |=> spinning);

  // R8
  spin_forces_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spinning |-> (pwm_out == !cfg_bits[4]));

  // R7
  auto_mode_duty_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && cfg_bits[7:5] != 3'b111) |=> $stable(duty_reg));
endmodule

bind fan_pwm_drv fan_pwm_drv_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .pwm_out(pwm_out),
  .cfg_bits(cfg_q), .duty_reg(duty_q), .duty_act(duty_act),
  .period_end(period_end), .spin_start(spin_start), .spinning(spinning)
);

// File: tb/test_fan_pwm_drv.sv
module test_fan_pwm_drv;
  localparam int UNIT = 1;
  localparam int MSD  = 2;

  logic       clk, rst_n, wr_en, tach_in;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       pwm_out;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  bit done = 0;

  fan_pwm_drv #(.STEP_UNIT(UNIT), .MS_DIV(MSD), .SYNC_STAGES(2)) i_fan_pwm_drv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tach_in(tach_in), .pwm_out(pwm_out)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", t, act, exp, cyc);
    end
  endtask

  function automatic int ms_of(input int s);
    case (s)
      1: return 100; 2: return 250; 3: return 400; 4: return 667;
      5: return 1000; 6: return 2000; 7: return 4000; default: return 0;
    endcase
  endfunction

  function automatic int mult_of(input int c);
    case (c)
      0: return 16; 1: return 12; 2: return 8; 3: return 6;
      4: return 5; 5: return 4; 6: return 3; default: return 2;
    endcase
  endfunction

  // behavioural reference model
  int m_duty, m_cfg, m_freq, m_cnt, m_pre, m_dact, m_fact, m_ms, m_el, m_tc;
  bit m_spin;
  bit sync_q[$];
  int n_pre, n_cnt, n_dact, n_fact, n_el, n_tc;
  bit n_spin, rise, tick, dwr, start, clr, stp, pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_duty = 255; m_cfg = 'hE2; m_freq = 4; m_cnt = 0; m_pre = 0;
      m_dact = 255; m_fact = 4; m_ms = 0; m_el = 0; m_tc = 0; m_spin = 0;
      sync_q = '{0, 0, 0};
    end else begin
      rise  = sync_q[1] && !sync_q[2];
      tick  = (m_ms == MSD - 1);
      dwr   = wr_en && wr_addr == 0 && ((m_cfg >> 5) == 7);
      start = dwr && m_duty == 0 && wr_data != 0 && (m_cfg & 7) != 0;
      clr   = dwr && wr_data == 0;
      n_spin = m_spin; n_el = m_el; n_tc = m_tc;
      if (start) begin
        n_spin = 1; n_el = 0; n_tc = 0;
      end else if (m_spin) begin
        if (clr) n_spin = 0;
        if (tick && m_el + 1 >= ms_of(m_cfg & 7)) n_spin = 0;
        if (((m_cfg >> 3) & 1) == 0 && rise && m_tc == 1) n_spin = 0;
        if (tick) n_el = m_el + 1;
        if (rise && m_tc < 2) n_tc = m_tc + 1;
      end
      stp  = (m_pre == UNIT * mult_of(m_fact) - 1);
      pend = stp && m_cnt == 254;
      n_pre = stp ? 0 : m_pre + 1;
      n_cnt = pend ? 0 : (stp ? m_cnt + 1 : m_cnt);
      n_dact = pend ? m_duty : m_dact;
      n_fact = pend ? m_freq : m_fact;
      if (dwr) m_duty = wr_data;
      if (wr_en && wr_addr == 1) m_cfg = wr_data;
      if (wr_en && wr_addr == 2) m_freq = wr_data & 7;
      sync_q.push_front(tach_in);
      void'(sync_q.pop_back());
      m_ms = tick ? 0 : m_ms + 1;
      m_spin = n_spin; m_el = n_el; m_tc = n_tc;
      m_pre = n_pre; m_cnt = n_cnt; m_dact = n_dact; m_fact = n_fact;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done)
      chk(tag, pwm_out, int'(m_spin || (m_cnt < m_dact)) ^ ((m_cfg >> 4) & 1));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic pulse();
    @(negedge clk); tach_in = 1;
    idle(4); tach_in = 0;
    idle(4);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    int hi;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; tach_in = 0;
    idle(5);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk("R1 reset output high", pwm_out, 1);
    measure(1300, hi);
    chk("R3 duty 0xFF solid", hi, 1300);

    tag = "R4";
    wr(2, 7); wr(0, 'h80);
    idle(1400);
    measure(510, hi);
    chk("R3 duty 0x80 high count", hi, 256);

    tag = "R3";
    wr(0, 0);
    idle(600);
    measure(510, hi);
    chk("R3 duty 0 silent", hi, 0);

    tag = "R12";
    wr(1, 'hE0); wr(0, 'h80);
    idle(600);
    measure(510, hi);
    chk("R12 no boost with code 000", hi, 256);

    tag = "R5";
    wr(2, 0); wr(0, 'h54);
    idle(700);
    measure(4080, hi);
    chk("R4 slowest code high count", hi, 1344);

    tag = "R6";
    wr(2, 7); wr(1, 'hF0); wr(0, 'h80);
    idle(4700);
    measure(510, hi);
    chk("R6 inverted high count", hi, 254);

    tag = "R7";
    wr(1, 'h02); wr(0, 'h20);
    idle(1200);
    measure(510, hi);
    chk("R7 duty write ignored", hi, 256);

    tag = "R2";
    wr(1, 'hE2); wr(3, 'h00);
    idle(600);
    measure(510, hi);
    chk("R2 address 3 ignored", hi, 256);

    tag = "R11";
    wr(0, 0); idle(600);
    wr(1, 'hE9); wr(0, 1);
    pulse(); pulse(); pulse();
    idle(250);

    tag = "R10";
    wr(0, 0); idle(600);
    wr(1, 'hE7); wr(0, 1);
    idle(100); pulse(); pulse();
    idle(300);

    tag = "R9";
    wr(0, 0); idle(600);
    wr(1, 'hE2); wr(0, 1);
    idle(700);

    tag = "R12";
    wr(0, 0); idle(600);
    wr(1, 'hE7); wr(0, 1);
    idle(50); wr(0, 0);
    idle(100);

    // tach end sweeping across the timeout tick
    tag = "R10";
    for (int k = 0; k < 12; k++) begin
      wr(0, 0); idle(3 + (k % 3));
      wr(1, 'hE1); wr(0, 1);
      idle(180 + k);
      pulse(); pulse();
      idle(40);
    end

    tag = "R8";
    wr(0, 0); idle(7);
    wr(1, 'hE1); wr(0, 'h40);
    idle(600);
    finish_run();
  end
endmodule